// File: doc/BRIEF.md
# Quadrature Rotary Direction Decoder

This block turns the two phase signals of a mechanical rotary encoder into step reports. Both phase inputs are already synchronized to the clock and debounced before they reach it. Each rising edge of phase A marks one detent step. The level that phase B has at that moment gives the direction of the turn.

For each step the block raises `rotary_event` for exactly one clock. In that cycle, `rotary_left` says whether the wheel turned left (B was already high when A rose) or right (B was still low). The consumer counts the steps, for example to drive an up/down register. Between steps, `rotary_left` holds the direction of the most recent step.

A parameter selects between a registered event output, which is the default and adds one cycle of latency, and a combinational one. A second parameter sets which level of B means a left turn.

Top module: `rotary_step_decoder`

## Requirements
- R1: With default parameters, `rotary_event` is high in the cycle after the clock edge at which `phase_a` is sampled high, provided it was sampled low at the edge before that.
- R2: Each detected step gives a `rotary_event` pulse exactly one cycle wide. Holding `phase_a` high, holding it low, and letting it fall produce no further events.
- R3: In an event cycle, `rotary_left` is 1 (left turn) when `phase_b` was sampled high at the edge where the rise of A was seen, and 0 (right turn) when it was sampled low.
- R4: Outside event cycles, `rotary_left` keeps its value. Changes of `phase_b` alone, and falling edges of `phase_a`, alter neither output.
- R5: While `rst` is high, and in the first cycle after it is released, both outputs are 0.
- R6: After reset the phase history is invalid for one edge. If `phase_a` is already high at the first edge after reset is released, no event is reported; an event needs a new low-to-high transition of A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| phase_a | input | 1 | Encoder phase A, synchronized and debounced |
| phase_b | input | 1 | Encoder phase B, synchronized and debounced |
| rotary_event | output | 1 | One-cycle pulse per detent step |
| rotary_left | output | 1 | Direction of the last step: 1 for left, 0 for right |

## Verification
The bench targets these cases:
- Phase A held high across the release of reset. A decoder that trusted its cleared history would report a phantom step.
- Long high and low holds on A. A level-triggered or stretched pulse shows up there as repeated or widened events.
- Isolated toggles of B and falling edges of A. They catch a direction flag that follows B outside event cycles, or a decoder that reacts to the wrong edge.
- Left and right steps back to back. A swapped polarity, or B sampled one cycle late, reports the wrong direction there.

// File: rtl/rotdec_pkg.sv
package rotdec_pkg;

   typedef struct packed {
      logic a;
      logic b;
   } phase_pair_t;

   localparam phase_pair_t PHASE_IDLE = '{a: 1'b0, b: 1'b0};

endpackage

// File: rtl/rotdec_phase_hist.sv
module rotdec_phase_hist
   import rotdec_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  phase_pair_t cur,
   output phase_pair_t prev,
   output logic        hist_ok
);

   // Previous-cycle copy of the phases plus a flag saying the copy is real.
   always_ff @(posedge clk) begin
      if (rst) begin
         prev    <= PHASE_IDLE;
         hist_ok <= 1'b0;
      end else begin
         prev    <= cur;
         hist_ok <= 1'b1;
      end
   end

endmodule

// File: rtl/rotdec_step_detect.sv
module rotdec_step_detect
   import rotdec_pkg::*;
#(
   parameter logic LEFT_B_LEVEL = 1'b1
) (
   input  phase_pair_t cur,
   input  phase_pair_t prev,
   input  logic        hist_ok,
   output logic        step,
   output logic        dir_left
);

   always_comb begin
      step     = hist_ok & cur.a & ~prev.a;
      dir_left = (cur.b == LEFT_B_LEVEL);
   end

endmodule

// File: rtl/rotdec_event_stage.sv
module rotdec_event_stage #(
   parameter int OUT_REG = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic step,
   input  logic dir_left,
   output logic event_o,
   output logic left_o
);

   logic held_left;

   always_ff @(posedge clk) begin
      if (rst)       held_left <= 1'b0;
      else if (step) held_left <= dir_left;
   end

   generate
      if (OUT_REG != 0) begin : g_registered
         logic ev_q;
         always_ff @(posedge clk) begin
            if (rst) ev_q <= 1'b0;
            else     ev_q <= step;
         end
         assign event_o = ev_q;
         assign left_o  = held_left;
      end else begin : g_direct
         assign event_o = step;
         assign left_o  = step ? dir_left : held_left;
      end
   endgenerate

endmodule

// File: rtl/rotary_step_decoder.sv
module rotary_step_decoder
   import rotdec_pkg::*;
#(
   parameter int   OUT_REG      = 1,
   parameter logic LEFT_B_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic phase_a,
   input  logic phase_b,
   output logic rotary_event,
   output logic rotary_left
);

   generate
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_out_reg
         $error("rotary_step_decoder: OUT_REG must be 0 or 1");
      end
   endgenerate

   phase_pair_t cur;
   phase_pair_t prev;
   logic        hist_ok;
   logic        step;
   logic        dir_left;

   assign cur = '{a: phase_a, b: phase_b};

   rotdec_phase_hist u_hist (
      .clk     (clk),
      .rst     (rst),
      .cur     (cur),
      .prev    (prev),
      .hist_ok (hist_ok)
   );

   rotdec_step_detect #(.LEFT_B_LEVEL(LEFT_B_LEVEL)) u_detect (
      .cur      (cur),
      .prev     (prev),
      .hist_ok  (hist_ok),
      .step     (step),
      .dir_left (dir_left)
   );

   rotdec_event_stage #(.OUT_REG(OUT_REG)) u_out (
      .clk      (clk),
      .rst      (rst),
      .step     (step),
      .dir_left (dir_left),
      .event_o  (rotary_event),
      .left_o   (rotary_left)
   );

endmodule

// File: rtl/rotdec_checker.sv
module rotdec_checker #(
   parameter int   OUT_REG      = 1,
   parameter logic LEFT_B_LEVEL = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic phase_a,
   input logic phase_b,
   input logic rotary_event,
   input logic rotary_left
);

   assert_pulse_width_R2: assert property (@(posedge clk) disable iff (rst)
      rotary_event |=> !rotary_event);

   assert_left_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !rotary_event |-> $stable(rotary_left));

   generate
      if (OUT_REG != 0) begin : g_reg_checks
         assert_event_on_rise_R1: assert property (@(posedge clk) disable iff (rst)
            rotary_event |-> ($past(phase_a) && !$past(phase_a, 2)));

         assert_direction_R3: assert property (@(posedge clk) disable iff (rst)
            rotary_event |-> (rotary_left == ($past(phase_b) == LEFT_B_LEVEL)));

         assert_no_event_after_reset_R6: assert property (@(posedge clk) disable iff (rst)
            ($past(rst, 2) && !$past(rst)) |-> !rotary_event);
      end else begin : g_direct_checks
         assert_event_on_rise_R1: assert property (@(posedge clk) disable iff (rst)
            rotary_event |-> (phase_a && !$past(phase_a)));

         assert_direction_R3: assert property (@(posedge clk) disable iff (rst)
            rotary_event |-> (rotary_left == (phase_b == LEFT_B_LEVEL)));

         assert_no_event_after_reset_R6: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !rotary_event);
      end
   endgenerate

endmodule

bind rotary_step_decoder rotdec_checker #(
   .OUT_REG      (OUT_REG),
   .LEFT_B_LEVEL (LEFT_B_LEVEL)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .phase_a      (phase_a),
   .phase_b      (phase_b),
   .rotary_event (rotary_event),
   .rotary_left  (rotary_left)
);

// File: tb/rotary_step_decoder_test.sv
`timescale 1ns/1ps
module rotary_step_decoder_test;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic a   = 1'b0;
   logic b   = 1'b0;
   logic ev;
   logic left;

   int checks = 0;
   int fails  = 0;
   int ev_count = 0;
   logic last_left = 1'b0;
   bit done = 1'b0;

   // model state
   logic m_prev = 1'b0;
   bit   m_hist = 1'b0;
   logic m_ev   = 1'b0;
   logic m_left = 1'b0;
   bit   m_rst_seen = 1'b1;

   always #2.5 clk = ~clk;

   rotary_step_decoder uut (
      .clk          (clk),
      .rst          (rst),
      .phase_a      (a),
      .phase_b      (b),
      .rotary_event (ev),
      .rotary_left  (left)
   );

   // behavioural reference: registered event, one cycle after the edge seeing the rise
   always @(posedge clk) begin
      m_rst_seen = rst;
      if (rst) begin
         m_prev = 1'b0;
         m_hist = 1'b0;
         m_ev   = 1'b0;
         m_left = 1'b0;
      end else begin
         m_ev = m_hist && a && !m_prev;
         if (m_ev) m_left = b;
         m_prev = a;
         m_hist = 1'b1;
      end
   end

   task automatic check(string tag, logic act, logic exp, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare every cycle away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         if (m_rst_seen) begin
            check("R5", ev, 1'b0, "event in reset");
            check("R5", left, 1'b0, "left in reset");
         end else begin
            check(m_ev ? "R1" : "R2", ev, m_ev, "event vs model");
            check(m_ev ? "R3" : "R4", left, m_left, "left vs model");
         end
         if (ev === 1'b1) begin
            ev_count++;
            last_left = left;
         end
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic step_right();
      a = 1'b1; cyc(3);
      b = 1'b1; cyc(3);
      a = 1'b0; cyc(3);
      b = 1'b0; cyc(3);
   endtask

   task automatic step_left();
      b = 1'b1; cyc(3);
      a = 1'b1; cyc(3);
      b = 1'b0; cyc(3);
      a = 1'b0; cyc(3);
   endtask

   initial begin
      int base;
      cyc(4);
      check("R5", ev, 1'b0, "reset event");
      check("R5", left, 1'b0, "reset left");
      rst = 1'b0;
      cyc(3);

      // R1/R3: right step
      base = ev_count;
      step_right();
      check("R1", logic'(ev_count == base + 1), 1'b1, "one event per right step");
      check("R3", last_left, 1'b0, "right direction");

      // R3: left step
      base = ev_count;
      step_left();
      check("R1", logic'(ev_count == base + 1), 1'b1, "one event per left step");
      check("R3", last_left, 1'b1, "left direction");

      // R2: A held high a long time
      base = ev_count;
      a = 1'b1; cyc(40);
      a = 1'b0; cyc(40);
      check("R2", logic'(ev_count == base + 1), 1'b1, "single pulse on long hold");

      // R4: B toggles alone, direction flag must stay
      base = ev_count;
      for (int i = 0; i < 6; i++) begin b = ~b; cyc(2); end
      b = 1'b0; cyc(2);
      check("R4", logic'(ev_count == base), 1'b1, "no event from B alone");
      check("R4", left, 1'b0, "left holds after B toggles");

      // back to back, fastest legal A toggling
      base = ev_count;
      for (int i = 0; i < 8; i++) begin
         b = i[0];
         a = 1'b1; cyc(1);
         a = 1'b0; cyc(1);
      end
      check("R2", logic'(ev_count == base + 8), 1'b1, "eight fast steps");
      cyc(3);

      // R6: A high across reset release
      a = 1'b1; b = 1'b1;
      rst = 1'b1; cyc(3);
      base = ev_count;
      rst = 1'b0; cyc(10);
      check("R6", logic'(ev_count == base), 1'b0 ^ 1'b1, "no event with A high at release");
      check("R5", left, 1'b0, "left cleared by reset");
      a = 1'b0; cyc(3);
      step_left();
      check("R6", logic'(ev_count == base + 1), 1'b1, "event after fresh rise");
      check("R3", last_left, 1'b1, "left after reset");

      cyc(4);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #100000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule